// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a programmable logic array. It takes the sum-of-products result computed for it and either passes it straight through or stores it in a one-bit register. The register can act as a data flop that captures the sum term, or as a toggle flop that inverts itself whenever the sum term is high. The register clock is one of two clocks, and each cell picks its own edge. Clock 0 is an external clock. Clock 1 may be external or may come from another cell's logic.

A group of six shared control terms drives the rest of the cell's behaviour. Two of them can clear or set the register at once, without waiting for a clock, and this feature can be switched off per cell. The output enable comes from one of the remaining four control terms, or it is forced on or forced off. An active-low global tristate input disables the output whatever the local choice.

The pad is modelled as a data value and an enable. Two feedback signals return to the routing array. One is the cell's own result, taken before the pad. The other is the pad itself, which carries the external input when the output is disabled. The configuration inputs are static settings and may only change while `rst_n` is low.

Top module: `mc_cell`

## Requirements
- R1: With `cfg_toggle`=0, the register takes the value of `sum_in` on each active edge of the selected clock and holds it between edges.
- R2: With `cfg_toggle`=1, the register inverts on an active edge when `sum_in` is 1 and keeps its value when `sum_in` is 0.
- R3: `cfg_clk_sel`=0 clocks the register from `clk0`, and `cfg_clk_sel`=1 clocks it from `clk1`. `cfg_clk_fall`=0 makes the rising edge active and `cfg_clk_fall`=1 the falling edge. Edges of the clock that is not selected have no effect.
- R4: With `cfg_init_en`=1, `ct[0]`=1 clears the register and `ct[1]`=1 sets it, at once and with no clock edge. When both are 1 the register is cleared.
- R5: With `cfg_init_en`=0, `ct[0]` and `ct[1]` have no effect on the register.
- R6: While `rst_n` is 0 the register is 0, whatever the clocks and control terms are doing.
- R7: The local enable is chosen by `cfg_oe_sel`. Codes 0 to 3 select `ct[2]` to `ct[5]`, code 4 forces the enable on, and codes 5 to 7 force it off.
- R8: While `gts_n` is 0, `pad_oe` is 0 whatever the local enable is.
- R9: With `cfg_bypass`=1, `pad_do` and `mc_fb` carry `sum_in` combinationally. With `cfg_bypass`=0 they both carry the register.
- R10: `pin_fb` equals `pad_do` while `pad_oe` is 1, and equals `pad_in` while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | External clock |
| clk1 | input | 1 | Second clock, external or produced by logic |
| rst_n | input | 1 | Active-low power-on clear of the register |
| sum_in | input | 1 | Sum-of-products result for this cell |
| ct | input | CT_COUNT (6) | Shared control terms |
| gts_n | input | 1 | Active-low global output disable |
| pad_in | input | 1 | Value seen on the pad from outside |
| cfg_toggle | input | 1 | 1 selects toggle flop, 0 selects data flop |
| cfg_clk_sel | input | 1 | Clock choice: 0 is clk0, 1 is clk1 |
| cfg_clk_fall | input | 1 | 1 makes the falling edge active |
| cfg_init_en | input | 1 | Enables clear and set from the control terms |
| cfg_oe_sel | input | 3 | Output-enable source code |
| cfg_bypass | input | 1 | 1 passes the sum term around the register |
| pad_do | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| mc_fb | output | 1 | Cell result fed back before the pad |
| pin_fb | output | 1 | Pad value fed back after the driver |

## Verification
Asynchronous clear, set and power-on clear act in the same instant as their inputs, and so do the enable, the bypass path and both feedback outputs. A registered result is due at the single active edge that falls within the clock period after a stimulus. The bench applies each stimulus 2 ns after a `clk0` rising edge. In that window it may also pulse `clk1` once, which gives one rising and one falling edge. It compares every output 1 ns after the next `clk0` rising edge, by which time exactly one active edge of the selected clock has occurred in every polarity mode. Asynchronous effects are also probed 1 ns after they are applied, well before any clock edge.

// File: rtl/mc_pkg.sv
package mc_pkg;
   // Default shape of the control-term group seen by one cell.
   localparam int unsigned MC_CT_COUNT    = 6;
   localparam int unsigned MC_RST_CT      = 0;
   localparam int unsigned MC_SET_CT      = 1;
   localparam int unsigned MC_OE_CT_BASE  = 2;
   localparam int unsigned MC_OE_CT_COUNT = 4;

   // Code width for "one of N terms, forced on, forced off".
   function automatic int unsigned oe_sel_width(input int unsigned n_terms);
      return $clog2(n_terms + 2);
   endfunction
endpackage

// File: rtl/mc_clock_sel.sv
module mc_clock_sel (
   input  logic clk0,
   input  logic clk1,
   input  logic sel,
   input  logic fall,
   output logic ck
);
   // The falling-edge choice becomes an inversion, so the flop always
   // triggers on a rising edge of ck.
   logic src;
   assign src = sel ? clk1 : clk0;
   assign ck  = src ^ fall;
endmodule

// File: rtl/mc_store.sv
module mc_store #(
   parameter bit RESET_WINS = 1'b1
) (
   input  logic ck,
   input  logic smp_clk,
   input  logic rst_n,
   input  logic toggle,
   input  logic d,
   input  logic init_en,
   input  logic ct_rst,
   input  logic ct_set,
   output logic q
);
   logic clr_req, set_req, clr_eff, set_eff, nxt;

   assign clr_req = init_en & ct_rst;
   assign set_req = init_en & ct_set;

   generate
      if (RESET_WINS) begin : g_clr_first
         assign clr_eff = clr_req;
         assign set_eff = set_req & ~clr_req;
      end else begin : g_set_first
         assign clr_eff = clr_req & ~set_req;
         assign set_eff = set_req;
      end
   endgenerate

   assign nxt = toggle ? (q ^ d) : d;

   always_ff @(posedge ck or negedge rst_n or posedge clr_eff or posedge set_eff) begin
      if (!rst_n)       q <= 1'b0;
      else if (clr_eff) q <= 1'b0;
      else if (set_eff) q <= 1'b1;
      else              q <= nxt;
   end

   // R4: a clear request holds the register at zero, even against a set.
   a_r4_clear_wins: assert property (@(posedge smp_clk) disable iff (!rst_n)
      (init_en && ct_rst && RESET_WINS) |-> !q);
   // R4: a lone set request holds the register at one.
   a_r4_set_holds: assert property (@(posedge smp_clk) disable iff (!rst_n)
      (init_en && ct_set && !ct_rst) |-> q);
endmodule

// File: rtl/mc_oe_ctl.sv
module mc_oe_ctl #(
   parameter int unsigned N_TERMS = 4,
   parameter int unsigned SEL_W   = 3
) (
   input  logic               smp_clk,
   input  logic               rst_n,
   input  logic [N_TERMS-1:0] terms,
   input  logic [SEL_W-1:0]   sel,
   input  logic               gts_n,
   output logic               oe
);
   localparam logic [SEL_W-1:0] FORCE_ON = SEL_W'(N_TERMS);

   logic local_en;

   always_comb begin
      local_en = 1'b0;
      for (int i = 0; i < int'(N_TERMS); i++)
         if (sel == SEL_W'(i)) local_en = terms[i];
      if (sel == FORCE_ON) local_en = 1'b1;
   end

   assign oe = gts_n & local_en;

   // R8: global disable overrides every local choice.
   a_r8_global_off: assert property (@(posedge smp_clk) disable iff (!rst_n)
      !gts_n |-> !oe);
   // R7: the forced-on code drives the pad when not globally disabled.
   a_r7_forced_on: assert property (@(posedge smp_clk) disable iff (!rst_n)
      (gts_n && sel == FORCE_ON) |-> oe);
   // R7: codes above the forced-on code keep the pad off.
   a_r7_forced_off: assert property (@(posedge smp_clk) disable iff (!rst_n)
      (sel > FORCE_ON) |-> !oe);
endmodule

// File: rtl/mc_cell.sv
module mc_cell
   import mc_pkg::*;
#(
   parameter int unsigned CT_COUNT    = MC_CT_COUNT,
   parameter int unsigned RST_CT      = MC_RST_CT,
   parameter int unsigned SET_CT      = MC_SET_CT,
   parameter int unsigned OE_CT_BASE  = MC_OE_CT_BASE,
   parameter int unsigned OE_CT_COUNT = MC_OE_CT_COUNT,
   parameter bit          RESET_WINS  = 1'b1,
   localparam int unsigned OE_SEL_W   = oe_sel_width(OE_CT_COUNT)
) (
   input  logic                clk0,
   input  logic                clk1,
   input  logic                rst_n,
   input  logic                sum_in,
   input  logic [CT_COUNT-1:0] ct,
   input  logic                gts_n,
   input  logic                pad_in,
   input  logic                cfg_toggle,
   input  logic                cfg_clk_sel,
   input  logic                cfg_clk_fall,
   input  logic                cfg_init_en,
   input  logic [OE_SEL_W-1:0] cfg_oe_sel,
   input  logic                cfg_bypass,
   output logic                pad_do,
   output logic                pad_oe,
   output logic                mc_fb,
   output logic                pin_fb
);
   generate
      if (OE_CT_BASE + OE_CT_COUNT > CT_COUNT) begin : g_bad_oe_range
         $error("mc_cell: enable terms run past the control-term group");
      end
      if (RST_CT >= OE_CT_BASE || SET_CT >= OE_CT_BASE || RST_CT == SET_CT) begin : g_bad_init_terms
         $error("mc_cell: clear/set terms must be distinct and below the enable terms");
      end
      if (OE_CT_COUNT == 0) begin : g_no_oe_terms
         $error("mc_cell: at least one enable term is needed");
      end
   endgenerate

   logic ck, q, result;

   mc_clock_sel u_clk (
      .clk0 (clk0),
      .clk1 (clk1),
      .sel  (cfg_clk_sel),
      .fall (cfg_clk_fall),
      .ck   (ck)
   );

   mc_store #(.RESET_WINS(RESET_WINS)) u_reg (
      .ck      (ck),
      .smp_clk (clk0),
      .rst_n   (rst_n),
      .toggle  (cfg_toggle),
      .d       (sum_in),
      .init_en (cfg_init_en),
      .ct_rst  (ct[RST_CT]),
      .ct_set  (ct[SET_CT]),
      .q       (q)
   );

   mc_oe_ctl #(.N_TERMS(OE_CT_COUNT), .SEL_W(OE_SEL_W)) u_oe (
      .smp_clk (clk0),
      .rst_n   (rst_n),
      .terms   (ct[OE_CT_BASE +: OE_CT_COUNT]),
      .sel     (cfg_oe_sel),
      .gts_n   (gts_n),
      .oe      (pad_oe)
   );

   assign result = cfg_bypass ? sum_in : q;
   assign pad_do = result;
   assign mc_fb  = result;
   assign pin_fb = pad_oe ? pad_do : pad_in;

   // R9: bypass routes the sum term to both the pad data and the cell feedback.
   a_r9_bypass_path: assert property (@(posedge clk0) disable iff (!rst_n)
      cfg_bypass |-> (pad_do == sum_in && mc_fb == sum_in));
   // R10: a disabled driver lets the outside value into the pad feedback.
   a_r10_pad_input: assert property (@(posedge clk0) disable iff (!rst_n)
      !pad_oe |-> (pin_fb == pad_in));
   // R10: an enabled driver reflects the cell's own data.
   a_r10_pad_drive: assert property (@(posedge clk0) disable iff (!rst_n)
      pad_oe |-> (pin_fb == pad_do));
endmodule

// File: tb/sim_mc_cell.sv
`timescale 1ns/1ps
module sim_mc_cell;
   logic clk0 = 1'b0, clk1 = 1'b0, rst_n = 1'b0;
   logic sum_in = 1'b0, gts_n = 1'b1, pad_in = 1'b0;
   logic [5:0] ct = '0;
   logic cfg_toggle = 1'b0, cfg_clk_sel = 1'b0, cfg_clk_fall = 1'b0;
   logic cfg_init_en = 1'b0, cfg_bypass = 1'b0;
   logic [2:0] cfg_oe_sel = 3'd0;
   logic pad_do, pad_oe, mc_fb, pin_fb;

   int n_cmp = 0, n_bad = 0;
   bit exp_q = 1'b0;
   string cur_tag = "R6";

   always #4 clk0 = ~clk0;   // 125 MHz

   mc_cell u0 (
      .clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sum_in(sum_in), .ct(ct),
      .gts_n(gts_n), .pad_in(pad_in), .cfg_toggle(cfg_toggle),
      .cfg_clk_sel(cfg_clk_sel), .cfg_clk_fall(cfg_clk_fall),
      .cfg_init_en(cfg_init_en), .cfg_oe_sel(cfg_oe_sel),
      .cfg_bypass(cfg_bypass), .pad_do(pad_do), .pad_oe(pad_oe),
      .mc_fb(mc_fb), .pin_fb(pin_fb)
   );

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit want_oe();
      if (!gts_n) return 1'b0;                       // R8
      if (cfg_oe_sel < 3'd4) return ct[2 + cfg_oe_sel]; // R7
      return cfg_oe_sel == 3'd4;                     // R7
   endfunction

   task automatic compare();
      bit e_do, e_oe;
      e_do = cfg_bypass ? sum_in : exp_q;
      e_oe = want_oe();
      check(cur_tag, "pad_do", pad_do, e_do);
      check(cfg_bypass ? "R9" : cur_tag, "mc_fb", mc_fb, e_do);
      check(gts_n ? "R7" : "R8", "pad_oe", pad_oe, e_oe);
      check("R10", "pin_fb", pin_fb, e_oe ? e_do : pad_in);
   endtask

   // One clk0 period: compare last result, drive, update reference, maybe pulse clk1.
   task automatic step(input string tag, input logic s, input logic [5:0] c,
                       input logic g, input logic p, input logic pl, input logic r);
      @(posedge clk0);
      #1 compare();
      #1;
      cur_tag = tag; rst_n = r; sum_in = s; ct = c; gts_n = g; pad_in = p;
      if (!r)                      exp_q = 1'b0;
      else if (cfg_init_en && c[0]) exp_q = 1'b0;
      else if (cfg_init_en && c[1]) exp_q = 1'b1;
      else if (cfg_clk_sel ? pl : 1'b1) exp_q = cfg_toggle ? (exp_q ^ s) : s;
      if (pl) begin
         #1 clk1 = 1'b1;
         #2 clk1 = 1'b0;
      end
   endtask

   task automatic recfg(input logic t, input logic cs, input logic cf,
                        input logic ie, input logic [2:0] oe, input logic bp);
      step("R6", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R6", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      cfg_toggle = t; cfg_clk_sel = cs; cfg_clk_fall = cf;
      cfg_init_en = ie; cfg_oe_sel = oe; cfg_bypass = bp;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      // R6: reset state with flop held clear
      step("R6", 1'b1, 6'b000000, 1'b1, 1'b1, 1'b1, 1'b0);

      // R1: data flop on clk0 rising edge, enable from ct[2]
      recfg(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
      step("R1", 1'b1, 6'b000100, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R1", 1'b0, 6'b000100, 1'b1, 1'b1, 1'b0, 1'b1);
      step("R1", 1'b1, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b1);
      step("R1", 1'b1, 6'b000100, 1'b0, 1'b0, 1'b0, 1'b1);

      // R3: data flop on clk0 falling edge
      recfg(1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R3", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);

      // R2: toggle flop, sum high toggles, sum low holds
      recfg(1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);
      step("R2", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R2", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R2", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R2", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R2", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);

      // R3: clk1 rising, clk0 edges without clk1 pulses must not clock
      recfg(1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R3", 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b1);

      // R3: data flop on clk1 falling edge
      recfg(1'b0, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0);
      step("R3", 1'b1, 6'd0, 1'b1, 1'b0, 1'b1, 1'b1);
      step("R3", 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R3", 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b1);

      // R4: asynchronous set, clear, and clear winning over set
      recfg(1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0);
      step("R4", 1'b0, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R4", "async set", pad_do, 1'b1);
      step("R4", 1'b0, 6'b000011, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R4", "clear beats set", pad_do, 1'b0);
      step("R4", 1'b0, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R4", "set after clear drops", pad_do, 1'b1);
      step("R4", 1'b0, 6'b000001, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R4", "async clear", pad_do, 1'b0);
      step("R4", 1'b1, 6'b000000, 1'b1, 1'b0, 1'b1, 1'b1);

      // R5: init disabled, control terms ignored
      recfg(1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);
      step("R5", 1'b1, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R5", 1'b1, 6'b000001, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R5", "clear ignored", pad_do, 1'b1);
      step("R5", 1'b0, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R5", 1'b0, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b1);
      #1 check("R5", "set ignored", pad_do, 1'b0);

      // R9: bypass
      recfg(1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1);
      step("R9", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);
      step("R9", 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 1'b1);
      step("R9", 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1);

      // R7 R8 R10: every enable code against term patterns and global disable
      for (int m = 0; m < 8; m++) begin
         recfg(1'b0, 1'b0, 1'b0, 1'b0, 3'(m), 1'b0);
         step("R7", 1'b1, 6'b010100, 1'b1, 1'b0, 1'b0, 1'b1);
         step("R7", 1'b0, 6'b101000, 1'b1, 1'b1, 1'b0, 1'b1);
         step("R8", 1'b1, 6'b111100, 1'b0, 1'b0, 1'b0, 1'b1);
         step("R10", 1'b1, 6'b111100, 1'b1, 1'b0, 1'b0, 1'b1);
      end

      // Mixed stimulus under random settings
      for (int k = 0; k < 600; k++) begin
         if (k % 30 == 0)
            recfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  3'($urandom), 1'($urandom % 4 == 0));
         step("R1", 1'($urandom), 6'($urandom), ($urandom % 6) != 0,
              1'($urandom), 1'($urandom), 1'b1);
      end

      @(posedge clk0);
      #1 compare();
      summary();
      $finish;
   end
endmodule